// File: doc/BRIEF.md
# Configurable-Mode SPI Burst Master

This block is a serial-peripheral-interface controller that drives a clock line and a master-out data line and samples a master-in data line. There is no select line; the surrounding logic frames the target device. A client first holds the lock input high. While it holds the lock, the client can program the clock idle level, the capture phase, the frame length of 1 to 8 bits and the half-period length in system clocks. It then requests a burst of frames. Each frame takes its bits from the top of one byte, most significant bit first.

Three burst kinds exist. A transmit-only burst pulls bytes from a valid/ready stream. A receive-only burst sends a constant fill byte on every frame. A full-duplex burst sends stream bytes and receives the same number of bytes. Received frames leave on a one-cycle valid strobe, left-aligned, with the unused low bits zero. Each frame starts with one fetch cycle at the idle level. If the stream has no byte ready, the clock waits at idle until one arrives. When the burst ends, the data-out line is forced low, the clock is at its idle level, and a one-cycle done strobe is raised.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, sclk and mosi are 0 and busy, done, rxValid and txReady are 0. The active settings are idle level 0, phase 0, 8-bit frames and a half period of DEF_DIV (250) system clocks.
- R2: A settings write is accepted only when all of these hold: lock is 1, the block is idle, cfgBits is between 1 and 8, and cfgDiv is nonzero. Any other write raises cfgErr for the following cycle and leaves every setting unchanged.
- R3: The fetch cycle of each frame holds sclk at the idle level. Every bit then spends exactly cfgDiv system clocks at the idle level, followed by exactly cfgDiv clocks at the opposite level.
- R4: A frame sends byte bits 7, 6, 5 and so on, for cfgBits bits. With fewer than 8 bits, the low bits of the byte are never sent.
- R5: With phase 0, mosi takes the new bit when the idle half starts, and miso is captured at the edge that takes sclk away from idle.
- R6: With phase 1, mosi takes the new bit at the edge that takes sclk away from idle, and miso is captured at the edge that returns sclk to idle. Between bits, mosi holds the last bit it sent.
- R7: In the cycle after the last half of the last frame, done is 1 for one cycle, mosi is 0 and sclk is at the idle level. mosi stays 0 for as long as the block is idle.
- R8: Burst kind codes on reqMode are 0 for transmit-only, 1 for receive-only and 2 for full-duplex. A receive-only burst sends fillByte as the byte of every frame and uses reqRxLen as the frame count.
- R9: A start request raises reqErr for the following cycle and causes no sclk activity when any of these holds: lock is 0, the block is busy, reqMode is 3, or a full-duplex request has reqTxLen different from reqRxLen.
- R10: In receive-only and full-duplex bursts, rxValid pulses in the cycle after each frame's last half. rxData then holds the captured bits in positions 7 downward, with the unused low bits 0. A transmit-only burst never raises rxValid.
- R11: A start request with a frame count of zero raises done in the next cycle, and sclk does not toggle.
- R12: Transmit-only and full-duplex bursts take exactly one stream byte per frame. txReady is high only in a fetch cycle. A receive-only burst takes no stream bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | Client holds the controller; required for settings and start |
| cfgWr | input | 1 | Settings write strobe |
| cfgPol | input | 1 | Clock idle level |
| cfgPha | input | 1 | Capture phase |
| cfgBits | input | 4 | Bits per frame, 1 to 8 |
| cfgDiv | input | DIV_W | Half-period length in system clocks |
| cfgErr | output | 1 | Settings write rejected (one cycle) |
| startReq | input | 1 | Burst start strobe |
| reqMode | input | 2 | Burst kind code |
| reqTxLen | input | LEN_W | Frames to send |
| reqRxLen | input | LEN_W | Frames to receive |
| fillByte | input | 8 | Byte sent in receive-only bursts |
| reqErr | output | 1 | Start request rejected (one cycle) |
| txData | input | 8 | Stream byte to send |
| txValid | input | 1 | Stream byte present |
| txReady | output | 1 | Stream byte taken this cycle when txValid is high |
| rxData | output | 8 | Received frame, left-aligned |
| rxValid | output | 1 | rxData valid (one cycle) |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst finished (one cycle) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is capture alignment across the four idle-level and phase settings, combined with short frames. A wrong edge choice only moves a bit by one position, and the shift is only visible if the device side responds to the real serial clock. The bench therefore models a device that advances its output on the edge opposite the capture edge and follows the bench's record of the active settings. Each burst is run with a different setting, frame length and half period, including 1-bit and 5-bit frames and a one-clock half period. The received bytes are compared with the device bytes after masking to the frame length. Rejected settings writes are shown to leave the settings untouched by running a burst afterwards and checking its waveform cycle by cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int FRAME_W = 8;
  localparam int BITS_W  = $clog2(FRAME_W + 1);

  localparam logic [1:0] KIND_TX   = 2'd0;
  localparam logic [1:0] KIND_RX   = 2'd1;
  localparam logic [1:0] KIND_BOTH = 2'd2;

  typedef enum logic [2:0] {
    MOSI_KEEP, MOSI_LOADBIT, MOSI_CUR, MOSI_NEXT, MOSI_ZERO
  } mosiSel_e;

  typedef enum logic [1:0] {
    SCLK_KEEP, SCLK_IDLE, SCLK_ACTIVE
  } sclkSel_e;

  typedef struct packed {
    logic     load;
    logic     useFill;
    mosiSel_e mosiSel;
    sclkSel_e sclkSel;
    logic     sample;
    logic     advance;
    logic     emit;
  } dpStrobe_t;
endpackage

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter logic DEF_POL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              pol,
  input  logic [BITS_W-1:0] bitsCfg,
  input  logic [FRAME_W-1:0] txData,
  input  logic [FRAME_W-1:0] fillByte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [FRAME_W-1:0] rxData,
  output logic              rxValid
);
  localparam logic [BITS_W-1:0] FULL_BITS = BITS_W'(FRAME_W);

  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-1:0] rxShift;
  logic [FRAME_W-1:0] byteIn;
  logic [FRAME_W-1:0] rxNext;
  logic [BITS_W-1:0]  padBits;

  assign byteIn  = strobe.useFill ? fillByte : txData;
  assign rxNext  = strobe.sample ? {rxShift[FRAME_W-2:0], miso} : rxShift;
  assign padBits = FULL_BITS - bitsCfg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      sclk    <= DEF_POL;
      mosi    <= 1'b0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      unique case (strobe.sclkSel)
        SCLK_IDLE:   sclk <= pol;
        SCLK_ACTIVE: sclk <= ~pol;
        default:     sclk <= sclk;
      endcase
      unique case (strobe.mosiSel)
        MOSI_LOADBIT: mosi <= byteIn[FRAME_W-1];
        MOSI_CUR:     mosi <= txShift[FRAME_W-1];
        MOSI_NEXT:    mosi <= txShift[FRAME_W-2];
        MOSI_ZERO:    mosi <= 1'b0;
        default:      mosi <= mosi;
      endcase
      if (strobe.load) begin
        txShift <= byteIn;
        rxShift <= '0;
      end else begin
        if (strobe.advance) txShift <= txShift << 1;
        if (strobe.sample)  rxShift <= rxNext;
      end
      if (strobe.emit) begin
        rxValid <= 1'b1;
        rxData  <= rxNext << padBits;
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int   DIV_W    = 16,
  parameter int   LEN_W    = 8,
  parameter int   DEF_DIV  = 250,
  parameter logic DEF_POL  = 1'b0,
  parameter logic DEF_PHA  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lock,
  input  logic              cfgWr,
  input  logic              cfgPol,
  input  logic              cfgPha,
  input  logic [BITS_W-1:0] cfgBits,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              startReq,
  input  logic [1:0]        reqMode,
  input  logic [LEN_W-1:0]  reqTxLen,
  input  logic [LEN_W-1:0]  reqRxLen,
  input  logic              txValid,
  output dpStrobe_t         strobe,
  output logic              pol,
  output logic [BITS_W-1:0] bitsCfg,
  output logic              txReady,
  output logic              busy,
  output logic              done,
  output logic              cfgErr,
  output logic              reqErr
);
  localparam logic [DIV_W-1:0]  DIV_ONE  = DIV_W'(1);
  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [BITS_W-1:0] BITS_ONE = BITS_W'(1);
  localparam logic [BITS_W-1:0] BITS_MAX = BITS_W'(FRAME_W);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_HALF_A, ST_HALF_B} state_e;

  state_e            state;
  logic              phaQ;
  logic [DIV_W-1:0]  divQ;
  logic [1:0]        kindQ;
  logic [LEN_W-1:0]  framesLeft;
  logic [BITS_W-1:0] bitsLeft;
  logic [DIV_W-1:0]  halfCnt;

  logic cfgOk, startOk, usesTx, byteReady, halfDone, lastBit, lastFrame;
  logic [LEN_W-1:0] reqLen;

  assign busy      = (state != ST_IDLE);
  assign cfgOk     = lock && !busy && (cfgBits >= BITS_ONE) && (cfgBits <= BITS_MAX)
                     && (cfgDiv != '0);
  assign startOk   = lock && !busy && (reqMode != 2'd3)
                     && ((reqMode != KIND_BOTH) || (reqTxLen == reqRxLen));
  assign reqLen    = (reqMode == KIND_RX) ? reqRxLen : reqTxLen;
  assign usesTx    = (kindQ != KIND_RX);
  assign txReady   = (state == ST_FETCH) && usesTx;
  assign byteReady = (state == ST_FETCH) && (!usesTx || txValid);
  assign halfDone  = (halfCnt == '0);
  assign lastBit   = (bitsLeft == BITS_ONE);
  assign lastFrame = (framesLeft == LEN_ONE);

  always_comb begin
    strobe = '{load: 1'b0, useFill: 1'b0, mosiSel: MOSI_KEEP, sclkSel: SCLK_KEEP,
               sample: 1'b0, advance: 1'b0, emit: 1'b0};
    unique case (state)
      ST_IDLE: begin
        strobe.sclkSel = SCLK_IDLE;
        strobe.mosiSel = MOSI_ZERO;
      end
      ST_FETCH: begin
        if (byteReady) begin
          strobe.load    = 1'b1;
          strobe.useFill = !usesTx;
          if (!phaQ) strobe.mosiSel = MOSI_LOADBIT;
        end
      end
      ST_HALF_A: begin
        if (halfDone) begin
          strobe.sclkSel = SCLK_ACTIVE;
          if (!phaQ) strobe.sample  = 1'b1;
          else       strobe.mosiSel = MOSI_CUR;
        end
      end
      default: begin
        if (halfDone) begin
          strobe.sclkSel = SCLK_IDLE;
          strobe.advance = 1'b1;
          if (phaQ) strobe.sample = 1'b1;
          if (lastBit) begin
            strobe.emit = (kindQ != KIND_TX);
            if (lastFrame) strobe.mosiSel = MOSI_ZERO;
          end else if (!phaQ) begin
            strobe.mosiSel = MOSI_NEXT;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pol        <= DEF_POL;
      phaQ       <= DEF_PHA;
      bitsCfg    <= BITS_MAX;
      divQ       <= DIV_W'(DEF_DIV);
      kindQ      <= KIND_TX;
      framesLeft <= '0;
      bitsLeft   <= '0;
      halfCnt    <= '0;
      done       <= 1'b0;
      cfgErr     <= 1'b0;
      reqErr     <= 1'b0;
    end else begin
      done   <= 1'b0;
      cfgErr <= 1'b0;
      reqErr <= 1'b0;
      if (cfgWr) begin
        if (cfgOk) begin
          pol     <= cfgPol;
          phaQ    <= cfgPha;
          bitsCfg <= cfgBits;
          divQ    <= cfgDiv;
        end else begin
          cfgErr <= 1'b1;
        end
      end
      if (startReq && !startOk) reqErr <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (startReq && startOk) begin
            kindQ <= reqMode;
            if (reqLen == '0) begin
              done <= 1'b1;
            end else begin
              framesLeft <= reqLen;
              state      <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (byteReady) begin
            bitsLeft <= bitsCfg;
            halfCnt  <= divQ - DIV_ONE;
            state    <= ST_HALF_A;
          end
        end
        ST_HALF_A: begin
          if (halfDone) begin
            halfCnt <= divQ - DIV_ONE;
            state   <= ST_HALF_B;
          end else begin
            halfCnt <= halfCnt - DIV_ONE;
          end
        end
        default: begin
          if (!halfDone) begin
            halfCnt <= halfCnt - DIV_ONE;
          end else if (!lastBit) begin
            bitsLeft <= bitsLeft - BITS_ONE;
            halfCnt  <= divQ - DIV_ONE;
            state    <= ST_HALF_A;
          end else if (lastFrame) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            framesLeft <= framesLeft - LEN_ONE;
            state      <= ST_FETCH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spim_pkg::*;
#(
  parameter int   DIV_W   = 16,
  parameter int   LEN_W   = 8,
  parameter int   DEF_DIV = 250,
  parameter logic DEF_POL = 1'b0,
  parameter logic DEF_PHA = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lock,
  input  logic             cfgWr,
  input  logic             cfgPol,
  input  logic             cfgPha,
  input  logic [3:0]       cfgBits,
  input  logic [DIV_W-1:0] cfgDiv,
  output logic             cfgErr,
  input  logic             startReq,
  input  logic [1:0]       reqMode,
  input  logic [LEN_W-1:0] reqTxLen,
  input  logic [LEN_W-1:0] reqRxLen,
  input  logic [7:0]       fillByte,
  output logic             reqErr,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  dpStrobe_t         strobe;
  logic              pol;
  logic [BITS_W-1:0] bitsCfg;

  spim_ctrl #(
    .DIV_W(DIV_W), .LEN_W(LEN_W), .DEF_DIV(DEF_DIV),
    .DEF_POL(DEF_POL), .DEF_PHA(DEF_PHA)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lock(lock), .cfgWr(cfgWr), .cfgPol(cfgPol),
    .cfgPha(cfgPha), .cfgBits(cfgBits), .cfgDiv(cfgDiv), .startReq(startReq),
    .reqMode(reqMode), .reqTxLen(reqTxLen), .reqRxLen(reqRxLen),
    .txValid(txValid), .strobe(strobe), .pol(pol), .bitsCfg(bitsCfg),
    .txReady(txReady), .busy(busy), .done(done), .cfgErr(cfgErr), .reqErr(reqErr)
  );

  spim_datapath #(.DEF_POL(DEF_POL)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pol(pol), .bitsCfg(bitsCfg),
    .txData(txData), .fillByte(fillByte), .miso(miso), .sclk(sclk),
    .mosi(mosi), .rxData(rxData), .rxValid(rxValid)
  );
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic mosi,
  input logic cfgWr,
  input logic cfgErr,
  input logic startReq,
  input logic reqErr,
  input logic rxValid,
  input logic txReady
);
  assert_mosi_low_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mosi);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !mosi));
  assert_cfgerr_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(cfgWr));
  assert_reqerr_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> $past(startReq));
  assert_rxvalid_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  assert_txready_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> busy);
endmodule

bind spi_burst_master spi_burst_master_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .mosi(mosi),
  .cfgWr(cfgWr), .cfgErr(cfgErr), .startReq(startReq), .reqErr(reqErr),
  .rxValid(rxValid), .txReady(txReady)
);

// File: tb/spi_burst_master_test.sv
module spi_burst_master_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lock = 1'b0, cfgWr = 1'b0, cfgPol = 1'b0, cfgPha = 1'b0;
  logic [3:0] cfgBits = 4'd8;
  logic [15:0] cfgDiv = 16'd1;
  logic startReq = 1'b0;
  logic [1:0] reqMode = 2'd0;
  logic [7:0] reqTxLen = '0, reqRxLen = '0, fillByte = '0;
  logic [7:0] txData;
  logic txValid = 1'b1;
  logic miso;
  logic cfgErr, reqErr, txReady, rxValid, busy, done, sclk, mosi;
  logic [7:0] rxData;

  always #10 clk = ~clk;

  spi_burst_master uut (
    .clk(clk), .rstN(rstN), .lock(lock), .cfgWr(cfgWr), .cfgPol(cfgPol),
    .cfgPha(cfgPha), .cfgBits(cfgBits), .cfgDiv(cfgDiv), .cfgErr(cfgErr),
    .startReq(startReq), .reqMode(reqMode), .reqTxLen(reqTxLen),
    .reqRxLen(reqRxLen), .fillByte(fillByte), .reqErr(reqErr), .txData(txData),
    .txValid(txValid), .txReady(txReady), .rxData(rxData), .rxValid(rxValid),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int nChecks = 0, nFail = 0;
  // model of the active settings
  logic mPol = 1'b0, mPha = 1'b0;
  int mBits = 8, mDiv = 250;

  logic [7:0] txMem [0:63];
  logic [7:0] respMem [0:15];
  int txIdx = 0;
  int lead = 0, trail = 0, leadBase = 0, trailBase = 0;
  logic [3:0] expQ[$];   // {sclk, mosi, rxValid, done}
  logic [7:0] rxGot[$];
  logic armed = 1'b0;

  function automatic void chk(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endfunction

  assign txData = txMem[txIdx];
  always @(posedge clk) if (txReady && txValid) txIdx <= txIdx + 1;

  // device model: output advances on the edge opposite the capture edge
  always @(sclk) begin
    if (sclk != mPol) lead = lead + 1;
    else trail = trail + 1;
  end
  always @* begin
    int k, bi, bp;
    k = mPha ? (lead - leadBase - 1) : (trail - trailBase);
    if (k < 0) k = 0;
    bi = k / mBits;
    bp = k % mBits;
    if (bi > 15) bi = 15;
    miso = respMem[bi][7 - bp];
  end

  always @(negedge clk) begin
    if (armed && expQ.size() > 0) begin
      logic [3:0] e;
      e = expQ.pop_front();
      chk(sclk == e[3], "R3 sclk", sclk, e[3]);
      chk(mosi == e[2], "R4 R5 R6 mosi", mosi, e[2]);
      chk(rxValid == e[1], "R10 rxValid", rxValid, e[1]);
      chk(done == e[0], "R7 done", done, e[0]);
    end
    if (rxValid) rxGot.push_back(rxData);
  end

  task automatic setCfg(input logic p, input logic h, input int b, input int d,
                        input logic lk, input logic expErr);
    @(negedge clk);
    lock = lk; cfgPol = p; cfgPha = h; cfgBits = 4'(b); cfgDiv = 16'(d); cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0; lock = 1'b1;
    chk(cfgErr == expErr, "R2 cfgErr", cfgErr, expErr);
    if (!expErr) begin mPol = p; mPha = h; mBits = b; mDiv = d; end
    repeat (2) @(negedge clk);
  endtask

  task automatic rejectStart(input logic [1:0] md, input int tl, input int rl,
                             input logic lk, input string tag);
    @(negedge clk);
    lock = lk; reqMode = md; reqTxLen = 8'(tl); reqRxLen = 8'(rl); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; lock = 1'b1;
    chk(reqErr == 1'b1, tag, reqErr, 1);
    chk(busy == 1'b0, tag, busy, 0);
    @(negedge clk);
    chk(sclk == mPol && !busy, tag, sclk, mPol);
  endtask

  task automatic runBurst(input logic [1:0] md, input int n, input logic [7:0] seed,
                          input logic [7:0] fill, input string tag);
    logic mLast;
    logic hasRx;
    logic [7:0] mask;
    int txStart;
    hasRx = (md != 2'd0);
    mask = 8'hFF << (8 - mBits);
    mLast = 1'b0;
    rxGot.delete();
    txStart = txIdx;
    for (int f = 0; f < n; f++) begin
      txMem[txIdx + f] = seed + 8'(f * 59);
      respMem[f] = ~seed ^ 8'(f * 97);
    end
    for (int f = 0; f < n; f++) begin
      logic [7:0] b;
      expQ.push_back({mPol, mLast, (f > 0) && hasRx, 1'b0});
      b = (md == 2'd1) ? fill : txMem[txIdx + f];
      for (int i = 0; i < mBits; i++) begin
        logic bt;
        bt = b[7 - i];
        for (int c = 0; c < mDiv; c++) expQ.push_back({mPol, mPha ? mLast : bt, 2'b00});
        for (int c = 0; c < mDiv; c++) expQ.push_back({~mPol, bt, 2'b00});
        mLast = bt;
      end
    end
    expQ.push_back({mPol, 1'b0, (n > 0) && hasRx, 1'b1});
    expQ.push_back({mPol, 3'b000});
    @(negedge clk);
    leadBase = lead; trailBase = trail;
    reqMode = md; fillByte = fill;
    reqTxLen = (md == 2'd1) ? 8'd7 : 8'(n);
    reqRxLen = (md == 2'd0) ? 8'd0 : 8'(n);
    startReq = 1'b1;
    @(posedge clk);
    #1 startReq = 1'b0; armed = 1'b1;
    while (expQ.size() > 0) @(negedge clk);
    armed = 1'b0;
    chk(rxGot.size() == (hasRx ? n : 0), {tag, " R10 rx count"}, rxGot.size(), hasRx ? n : 0);
    if (hasRx)
      for (int f = 0; f < n && f < rxGot.size(); f++)
        chk(rxGot[f] == (respMem[f] & mask), {tag, " R10 rxData"}, rxGot[f], respMem[f] & mask);
    chk(txIdx - txStart == ((md == 2'd1) ? 0 : n), {tag, " R12 bytes taken"},
        txIdx - txStart, (md == 2'd1) ? 0 : n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(!busy && !done && !rxValid && !txReady, "R1 status", {busy, done, rxValid, txReady}, 0);
    rstN = 1'b1;
    lock = 1'b1;
    repeat (2) @(negedge clk);
    // R1 default settings, R4 R5 bit order with phase 0
    runBurst(2'd0, 1, 8'hA5, 8'h00, "R1 default");
    setCfg(1'b0, 1'b0, 8, 3, 1'b1, 1'b0);
    runBurst(2'd2, 3, 8'h3C, 8'h00, "R5 duplex");
    setCfg(1'b1, 1'b1, 8, 2, 1'b1, 1'b0);
    runBurst(2'd2, 2, 8'h96, 8'h00, "R6 duplex");
    setCfg(1'b0, 1'b1, 5, 2, 1'b1, 1'b0);
    runBurst(2'd1, 2, 8'h71, 8'hC3, "R8 fill");
    setCfg(1'b1, 1'b0, 1, 1, 1'b1, 1'b0);
    runBurst(2'd0, 2, 8'h80, 8'h00, "R10 tx only");
    runBurst(2'd0, 0, 8'h00, 8'h00, "R11 zero length");
    // R2 rejected writes leave settings untouched
    setCfg(1'b0, 1'b1, 4, 5, 1'b0, 1'b1);
    setCfg(1'b0, 1'b1, 0, 5, 1'b1, 1'b1);
    setCfg(1'b0, 1'b1, 9, 5, 1'b1, 1'b1);
    setCfg(1'b0, 1'b1, 4, 0, 1'b1, 1'b1);
    runBurst(2'd2, 2, 8'h4E, 8'h00, "R2 unchanged");
    // R9 rejected starts
    rejectStart(2'd2, 2, 3, 1'b1, "R9 length mismatch");
    rejectStart(2'd0, 1, 0, 1'b0, "R9 no lock");
    rejectStart(2'd3, 1, 1, 1'b1, "R9 bad kind");
    setCfg(1'b0, 1'b0, 7, 2, 1'b1, 1'b0);
    runBurst(2'd2, 1, 8'hE7, 8'h00, "R4 seven bits");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule